// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This block gathers the interrupt sources of a USB device controller into one status register and one level interrupt line for the processor. There are eight per-endpoint event pulses, a start-of-frame pulse, a suspend pulse, an end-of-bus-reset pulse and a wakeup pulse. The bus-event pulses arrive already synchronized to the block clock. Each pulse sets a sticky status bit. Software acknowledges a bit by writing a one to that bit position.

Software selects which sources may raise the interrupt through a mask. The mask is changed through a pair of write-one registers, one that sets mask bits and one that clears them. The current mask can be read back. End-of-bus-reset and wakeup always reach the interrupt output, whatever the mask holds. Software is expected to read the pending word and to service bus reset first, then wakeup, then the endpoints in ascending order. The block also tracks whether the bus is suspended, so that a start-of-frame pulse seen during suspend does not record a frame.

Top module: `usb_irq_unit`

## Requirements
- R1: An event pulse sets its status bit at the next clock edge. The bit positions are: endpoint n at bit n (0 to 7), start-of-frame at bit 8, suspend at bit 9, end-of-bus-reset at bit 10, wakeup at bit 11.
- R2: A status bit stays set until a write to address 4 carries a 1 in that bit position. Zero bits in that write leave status unchanged.
- R3: If an event and a clear of the same bit occur in the same cycle, the bit stays set.
- R4: A write to address 0 sets every mask bit whose data bit is 1. A write to address 1 clears every mask bit whose data bit is 1. Address 2 reads the mask and address 3 reads the status.
- R5: The interrupt output is a register, active high. It is high one cycle after any status bit whose mask bit is 1 is set, which is two edges after the event pulse.
- R6: Status bits 10 (end-of-bus-reset) and 11 (wakeup) drive the interrupt output regardless of the mask.
- R7: A suspend pulse puts the block in the suspended state. An end-of-bus-reset or wakeup pulse leaves that state. While the block is suspended, start-of-frame pulses do not set bit 8.
- R8: Address 5 reads the pending word: status AND (mask OR bits 10 and 11).
- R9: Writes to the read-only addresses (2, 3, 5) and to the unused addresses (6, 7) change neither status nor mask.
- R10: A synchronous reset clears the status, the mask, the suspended state and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_evt | input | N_EP (8) | Per-endpoint event pulses |
| sof_evt | input | 1 | Start-of-frame pulse |
| susp_evt | input | 1 | Suspend detected pulse |
| busrst_evt | input | 1 | End-of-bus-reset pulse |
| wake_evt | input | 1 | Wakeup/resume pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_EP+4 (12) | Register write data |
| reg_rdata | output | N_EP+4 (12) | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that lets the clear win would lose that event, and the bench would read status bit 7 as 0. Bus reset and wakeup are raised while their mask bits are 0. A design that masks them would keep irq low. Start-of-frame pulses are sent both before and after a wakeup that ends a suspend. A design that does not track suspend would record the frame too early, and one that never leaves suspend would drop the later frame. Writes to read-only and unused addresses, the pending readback, and a reset taken during suspend are also checked. These would catch a decoder that aliases addresses, a pending word that ignores the unmaskable bits, and a suspended state that survives reset.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    // Register selectors on reg_addr
    typedef enum logic [2:0] {
        SEL_MASK_SET = 3'd0,
        SEL_MASK_CLR = 3'd1,
        SEL_MASK_RD  = 3'd2,
        SEL_STAT_RD  = 3'd3,
        SEL_STAT_ACK = 3'd4,
        SEL_PEND_RD  = 3'd5
    } reg_sel_e;

    // Bus-event sources sit above the endpoint bits, at these offsets
    localparam int OFS_SOF   = 0;
    localparam int OFS_SUSP  = 1;
    localparam int OFS_BRST  = 2;
    localparam int OFS_WAKE  = 3;
    localparam int N_BUS_SRC = 4;

endpackage

// File: rtl/usbirq_mask.sv
module usbirq_mask #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] mask_q
);

    logic [NSRC-1:0] mask_d;

    always_comb begin
        mask_d = (mask_q | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

endmodule

// File: rtl/usbirq_status.sv
module usbirq_status #(
    parameter int N_EP = 8,
    localparam int NSRC = N_EP + usbirq_pkg::N_BUS_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_vec,
    input  logic [NSRC-1:0] ack_vec,
    output logic [NSRC-1:0] stat_q,
    output logic            susp_q
);
    import usbirq_pkg::*;

    localparam int B_SOF  = N_EP + OFS_SOF;
    localparam int B_SUSP = N_EP + OFS_SUSP;
    localparam int B_BRST = N_EP + OFS_BRST;
    localparam int B_WAKE = N_EP + OFS_WAKE;

    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic            susp;
    } st_t;

    st_t             cur_q, nxt_d;
    logic [NSRC-1:0] set_eff;

    always_comb begin
        nxt_d = cur_q;
        // A frame marker is not recorded while the bus is suspended
        for (int i = 0; i < NSRC; i++) begin
            if (i == B_SOF) set_eff[i] = evt_vec[i] & ~cur_q.susp;
            else            set_eff[i] = evt_vec[i];
        end
        // A new event takes precedence over a clear of the same bit
        nxt_d.stat = (cur_q.stat & ~ack_vec) | set_eff;
        if (evt_vec[B_WAKE] || evt_vec[B_BRST]) nxt_d.susp = 1'b0;
        else if (evt_vec[B_SUSP])               nxt_d.susp = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign stat_q = cur_q.stat;
    assign susp_q = cur_q.susp;

endmodule

// File: rtl/usbirq_out.sv
module usbirq_out #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] stat_q,
    input  logic [NSRC-1:0] mask_q,
    input  logic [NSRC-1:0] force_vec,
    output logic [NSRC-1:0] pend,
    output logic            irq_q
);

    logic irq_d;

    always_comb begin
        pend  = stat_q & (mask_q | force_vec);
        irq_d = |pend;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit #(
    parameter int N_EP = 8,
    localparam int NSRC = N_EP + usbirq_pkg::N_BUS_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EP-1:0] ep_evt,
    input  logic            sof_evt,
    input  logic            susp_evt,
    input  logic            busrst_evt,
    input  logic            wake_evt,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq
);
    import usbirq_pkg::*;

    localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};
    localparam logic [NSRC-1:0] UNMASKABLE =
        (ONE << (N_EP + OFS_BRST)) | (ONE << (N_EP + OFS_WAKE));

    logic [NSRC-1:0] src_ev, ack_vec, mset_vec, mclr_vec;
    logic [NSRC-1:0] stat_q, mask_q, pend;
    logic            susp_q;

    always_comb begin
        src_ev   = {wake_evt, busrst_evt, susp_evt, sof_evt, ep_evt};
        mset_vec = '0;
        mclr_vec = '0;
        ack_vec  = '0;
        if (reg_wr) begin
            case (reg_addr)
                SEL_MASK_SET: mset_vec = reg_wdata;
                SEL_MASK_CLR: mclr_vec = reg_wdata;
                SEL_STAT_ACK: ack_vec  = reg_wdata;
                default:      ;
            endcase
        end
    end

    usbirq_mask #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_vec (mset_vec),
        .clr_vec (mclr_vec),
        .mask_q  (mask_q)
    );

    usbirq_status #(.N_EP(N_EP)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt_vec (src_ev),
        .ack_vec (ack_vec),
        .stat_q  (stat_q),
        .susp_q  (susp_q)
    );

    usbirq_out #(.NSRC(NSRC)) u_out (
        .clk       (clk),
        .rst       (rst),
        .stat_q    (stat_q),
        .mask_q    (mask_q),
        .force_vec (UNMASKABLE),
        .pend      (pend),
        .irq_q     (irq)
    );

    always_comb begin
        case (reg_addr)
            SEL_MASK_RD: reg_rdata = mask_q;
            SEL_STAT_RD: reg_rdata = stat_q;
            SEL_PEND_RD: reg_rdata = pend;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk #(
    parameter int N_EP = 8,
    localparam int NSRC = N_EP + 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] ev,
    input logic [NSRC-1:0] clr,
    input logic [NSRC-1:0] stat,
    input logic [NSRC-1:0] mask,
    input logic            susp,
    input logic            irq
);
    localparam logic [NSRC-1:0] ONE  = {{(NSRC-1){1'b0}}, 1'b1};
    localparam logic [NSRC-1:0] SOFB = ONE << N_EP;
    localparam logic [NSRC-1:0] UNM  = (ONE << (N_EP + 2)) | (ONE << (N_EP + 3));

    // R1
    ev_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ev & ~SOFB)) |=> ((stat & $past(ev & ~SOFB)) == $past(ev & ~SOFB)));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat) & ~$past(clr)) & ~stat) == '0));

    // R3
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~ev)) |=> ((stat & $past(clr & ~ev)) == '0));

    // R5
    irq_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(stat & mask)) || $past(|(stat & UNM))));

    // R6
    unmask_chk: assert property (@(posedge clk) disable iff (rst)
        (|(stat & UNM)) |=> irq);

    // R7
    sof_susp_chk: assert property (@(posedge clk) disable iff (rst)
        (susp && ev[N_EP] && !stat[N_EP]) |=> !stat[N_EP]);

    // R10
    rst_chk: assert property (@(posedge clk)
        rst |=> (stat == '0 && mask == '0 && !susp && !irq));

endmodule

bind usb_irq_unit usbirq_chk #(.N_EP(N_EP)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .ev   (src_ev),
    .clr  (ack_vec),
    .stat (stat_q),
    .mask (mask_q),
    .susp (susp_q),
    .irq  (irq)
);

// File: tb/sim_usb_irq_unit.sv
module sim_usb_irq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ep_evt = '0;
    logic        sof_evt = 1'b0, susp_evt = 1'b0, busrst_evt = 1'b0, wake_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    usb_irq_unit u0 (
        .clk(clk), .rst(rst), .ep_evt(ep_evt), .sof_evt(sof_evt),
        .susp_evt(susp_evt), .busrst_evt(busrst_evt), .wake_evt(wake_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] ev;
        logic        wr;
        logic [2:0]  addr;
        logic [11:0] wd;
        logic [11:0] es;
        logic [11:0] em;
        logic        eirq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [0:NV-1] = '{
        '{12'h001, 1'b0, 3'd0, 12'h000, 12'h001, 12'h000, 1'b0}, // R1 ep0 masked off
        '{12'h000, 1'b1, 3'd0, 12'h001, 12'h001, 12'h001, 1'b1}, // R4 R5 enable ep0
        '{12'h000, 1'b1, 3'd4, 12'h001, 12'h000, 12'h001, 1'b0}, // R2 clear ep0
        '{12'h100, 1'b0, 3'd0, 12'h000, 12'h100, 12'h001, 1'b0}, // R1 sof unmasked off
        '{12'h000, 1'b1, 3'd0, 12'h100, 12'h100, 12'h101, 1'b1}, // R4 enable sof
        '{12'h000, 1'b1, 3'd1, 12'h100, 12'h100, 12'h001, 1'b0}, // R4 disable sof
        '{12'h400, 1'b0, 3'd0, 12'h000, 12'h500, 12'h001, 1'b1}, // R6 bus reset
        '{12'h000, 1'b1, 3'd4, 12'h400, 12'h100, 12'h001, 1'b0}, // R2 clear one bit only
        '{12'h800, 1'b0, 3'd0, 12'h000, 12'h900, 12'h001, 1'b1}, // R6 wakeup
        '{12'h000, 1'b1, 3'd4, 12'h900, 12'h000, 12'h001, 1'b0}, // R2
        '{12'h200, 1'b0, 3'd0, 12'h000, 12'h200, 12'h001, 1'b0}, // R1 suspend bit
        '{12'h100, 1'b0, 3'd0, 12'h000, 12'h200, 12'h001, 1'b0}, // R7 sof dropped
        '{12'h800, 1'b0, 3'd0, 12'h000, 12'hA00, 12'h001, 1'b1}, // R7 wake leaves suspend
        '{12'h100, 1'b0, 3'd0, 12'h000, 12'hB00, 12'h001, 1'b1}, // R7 sof recorded again
        '{12'h000, 1'b1, 3'd4, 12'hFFF, 12'h000, 12'h001, 1'b0}, // R2 clear all
        '{12'h080, 1'b0, 3'd0, 12'h000, 12'h080, 12'h001, 1'b0}, // R1 ep7
        '{12'h000, 1'b1, 3'd0, 12'h080, 12'h080, 12'h081, 1'b1}, // R5 ep7 enabled
        '{12'h000, 1'b1, 3'd1, 12'hFFF, 12'h080, 12'h000, 1'b0}, // R4 disable all
        '{12'h080, 1'b1, 3'd4, 12'h080, 12'h080, 12'h000, 1'b0}, // R3 event beats clear
        '{12'h000, 1'b1, 3'd4, 12'h080, 12'h000, 12'h000, 1'b0}, // R2
        '{12'h000, 1'b1, 3'd7, 12'hFFF, 12'h000, 12'h000, 1'b0}, // R9 unused address
        '{12'h000, 1'b1, 3'd2, 12'hFFF, 12'h000, 12'h000, 1'b0}  // R9 read-only address
    };

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic drive_ev(input logic [11:0] ev);
        ep_evt = ev[7:0]; sof_evt = ev[8]; susp_evt = ev[9];
        busrst_evt = ev[10]; wake_evt = ev[11];
    endtask

    // Apply one cycle of stimulus at a negedge, settle two edges, return at a negedge
    task automatic step(input logic [11:0] ev, input logic wr, input logic [2:0] a,
                        input logic [11:0] wd);
        drive_ev(ev); reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(posedge clk); @(negedge clk);
        drive_ev('0); reg_wr = 1'b0; reg_wdata = '0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(3'd3, v); chk("R10 status", v, 12'h000);
        rd(3'd2, v); chk("R10 mask", v, 12'h000);
        chk("R10 irq", {11'd0, irq}, 12'h000);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].ev, TBL[i].wr, TBL[i].addr, TBL[i].wd);
            rd(3'd3, v); chk($sformatf("R1/R2/R3/R9 status row %0d", i), v, TBL[i].es);
            rd(3'd2, v); chk($sformatf("R4/R9 mask row %0d", i), v, TBL[i].em);
            chk($sformatf("R5/R6 irq row %0d", i), {11'd0, irq}, {11'd0, TBL[i].eirq});
        end

        // R8 pending word
        step(12'h008, 1'b0, 3'd0, 12'h000);
        rd(3'd5, v); chk("R8 pending masked", v, 12'h000);
        step(12'h000, 1'b1, 3'd0, 12'h008);
        rd(3'd5, v); chk("R8 pending ep3", v, 12'h008);
        step(12'h400, 1'b0, 3'd0, 12'h000);
        rd(3'd5, v); chk("R8 pending bus reset unmasked", v, 12'h408);
        // R9 write to pending address ignored
        step(12'h000, 1'b1, 3'd5, 12'hFFF);
        rd(3'd3, v); chk("R9 status after pend write", v, 12'h408);
        rd(3'd2, v); chk("R9 mask after pend write", v, 12'h008);

        // R10 reset during suspend, then sof must be recorded
        step(12'h200, 1'b0, 3'd0, 12'h000);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        rd(3'd3, v); chk("R10 status after reset", v, 12'h000);
        rd(3'd2, v); chk("R10 mask after reset", v, 12'h000);
        chk("R10 irq after reset", {11'd0, irq}, 12'h000);
        step(12'h100, 1'b0, 3'd0, 12'h000);
        rd(3'd3, v); chk("R10 R7 sof after reset", v, 12'h100);

        // R7 bus reset also leaves suspend
        step(12'h000, 1'b1, 3'd4, 12'hFFF);
        step(12'h200, 1'b0, 3'd0, 12'h000);
        step(12'h400, 1'b0, 3'd0, 12'h000);
        step(12'h100, 1'b0, 3'd0, 12'h000);
        rd(3'd3, v); chk("R7 sof after bus reset", v, 12'h700);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule